// File: doc/BRIEF.md
# Frequency Lock Detector and Trainer

This block supervises a multirate clock and data recovery loop from the digital side. It runs in the local reference clock domain. A pulse stream derived from the recovered clock comes in, already prescaled and synchronized, with at most one pulse per reference cycle. The block counts these pulses over a fixed window of reference cycles. It then compares the count with the value expected for the selected line rate. The recovered-to-reference frequency ratio is 32 at the high rate and 8 at the low rate, and the allowed deviation is a parameter in ppm.

The block drives a lock indication and a train-to-reference control. After reset, and after any failed measurement, the control holds the loop on the reference for a fixed training interval. It then releases the loop so it can acquire the data, and a new measurement starts. The lock output is set only after a run of consecutive good measurements, so a far-off frequency keeps it low and it does not toggle. A low signal-detect input, a low force-to-reference input or a change of rate select clears the lock at once and restarts training.

Top module: `freq_lock_trainer`

## Requirements
- R1: The expected pulse count per window is 2^WIN_LOG2 × 32 / 2^PRESCALE_LOG2 when `rate_hi` is 1 and 2^WIN_LOG2 × 8 / 2^PRESCALE_LOG2 when it is 0. A stream that is nominal for one rate never locks while the other rate is selected.
- R2: A window counts as good when its pulse count lies within ±floor(expected × PPM / 10^6) of the expected count, both limits included. One count beyond either limit makes the window bad.
- R3: While `force_ref_n` is 0, `lock` is 0 and `train_ref` is 1 in the same cycle. After it returns to 1, lock is regained only through a full new training and measurement sequence.
- R4: While `sig_det` is 0, `lock` is 0 and `train_ref` is 1 in the same cycle. After it returns to 1, the full training and measurement sequence restarts.
- R5: `lock` rises exactly TRAIN_LEN + 2 × WIN_LEN reference cycles after training starts, given two consecutive good windows. A single good window does not set it.
- R6: One bad window while locked clears `lock`. `train_ref` is then asserted for exactly 2^TRAIN_LOG2 cycles before the next window.
- R7: While the frequency stays out of tolerance, training and measurement repeat without limit, and `lock` stays 0 for the whole time.
- R8: During reset `lock` is 0 and `train_ref` is 1.
- R9: A change of `rate_hi` clears `lock` in the same cycle and restarts training.
- R10: `train_ref` is 0 whenever `lock` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_pulse | input | 1 | Prescaled recovered-clock event, one cycle wide, synchronized to clk |
| rate_hi | input | 1 | Rate select: 1 selects multiplier 32, 0 selects multiplier 8 |
| sig_det | input | 1 | Signal detect; 0 forces lock off and training on |
| force_ref_n | input | 1 | Active-low force to reference |
| lock | output | 1 | Frequency lock indication |
| train_ref | output | 1 | Steers the loop onto the reference while 1 |

## Verification
The pulse stream comes from a phase accumulator, so every window holds exactly the chosen number of pulses. The stimulus covers nominal rates in both modes, each mode's rate applied with the other mode selected, and counts at and one beyond each tolerance limit; these separate a correct bound from an off-by-one bound and a wrong multiplier. Random offsets around nominal in both modes are checked against a computed lock expectation. Directed sequences drop signal detect, force to reference, the rate select and the frequency while locked, which separates the immediate clear paths from the window-end path and confirms the exact relock and training-length timing.

// File: rtl/lfd_pkg.sv
package lfd_pkg;

    localparam int MULT_HIGH_RATE = 32;
    localparam int MULT_LOW_RATE  = 8;

    typedef enum logic {
        PH_TRAIN = 1'b0,
        PH_MEAS  = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   locked;
    } ctl_t;

    function automatic longint nominal_count(int win_log2, int presc_log2, int mult);
        return ((longint'(1) << win_log2) * longint'(mult)) >>> presc_log2;
    endfunction

    function automatic longint tolerance_count(longint nom, int ppm);
        return (nom * longint'(ppm)) / longint'(1000000);
    endfunction

    function automatic longint lower_bound(longint nom, longint tol);
        return (nom > tol) ? (nom - tol) : longint'(0);
    endfunction

endpackage

// File: rtl/lfd_timer.sv
module lfd_timer #(
    parameter int TRAIN_LOG2 = 12,
    parameter int WIN_LOG2   = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sel_train,
    output logic last
);
    localparam int TW = (TRAIN_LOG2 > WIN_LOG2) ? TRAIN_LOG2 : WIN_LOG2;
    localparam logic [TW-1:0] TRAIN_LAST = TW'((longint'(1) << TRAIN_LOG2) - 1);
    localparam logic [TW-1:0] WIN_LAST   = TW'((longint'(1) << WIN_LOG2) - 1);

    logic [TW-1:0] tmr_q;

    always_comb begin
        last = (tmr_q == (sel_train ? TRAIN_LAST : WIN_LAST));
    end

    always_ff @(posedge clk) begin
        if (rst || clear || last) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end
endmodule

// File: rtl/lfd_pulse_acc.sv
module lfd_pulse_acc #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic          close,
    input  logic          pulse,
    output logic [CW-1:0] total
);
    logic [CW-1:0] cnt_q;

    always_comb begin
        total = cnt_q + CW'(pulse);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || close) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= total;
        end
    end
endmodule

// File: rtl/lfd_judge.sv
module lfd_judge
    import lfd_pkg::*;
#(
    parameter int CW            = 20,
    parameter int WIN_LOG2      = 14,
    parameter int PRESCALE_LOG2 = 5,
    parameter int PPM           = 500
) (
    input  logic          rate_hi,
    input  logic [CW-1:0] total,
    output logic          in_tol
);
    localparam longint NOM_HI = nominal_count(WIN_LOG2, PRESCALE_LOG2, MULT_HIGH_RATE);
    localparam longint NOM_LO = nominal_count(WIN_LOG2, PRESCALE_LOG2, MULT_LOW_RATE);
    localparam longint TOL_HI = tolerance_count(NOM_HI, PPM);
    localparam longint TOL_LO = tolerance_count(NOM_LO, PPM);

    localparam logic [CW-1:0] MIN_HI = CW'(lower_bound(NOM_HI, TOL_HI));
    localparam logic [CW-1:0] MAX_HI = CW'(NOM_HI + TOL_HI);
    localparam logic [CW-1:0] MIN_LO = CW'(lower_bound(NOM_LO, TOL_LO));
    localparam logic [CW-1:0] MAX_LO = CW'(NOM_LO + TOL_LO);

    logic [CW-1:0] min_sel;
    logic [CW-1:0] max_sel;

    always_comb begin
        min_sel = rate_hi ? MIN_HI : MIN_LO;
        max_sel = rate_hi ? MAX_HI : MAX_LO;
        in_tol  = (total >= min_sel) && (total <= max_sel);
    end
endmodule

// File: rtl/freq_lock_trainer.sv
module freq_lock_trainer
    import lfd_pkg::*;
#(
    parameter int WIN_LOG2      = 14,
    parameter int TRAIN_LOG2    = 12,
    parameter int PRESCALE_LOG2 = 5,
    parameter int PPM           = 500,
    parameter int CONFIRM_WINS  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rec_pulse,
    input  logic rate_hi,
    input  logic sig_det,
    input  logic force_ref_n,
    output logic lock,
    output logic train_ref
);
    localparam int CW = WIN_LOG2 + 6;
    localparam int SW = $clog2(CONFIRM_WINS + 1);
    localparam logic [SW-1:0] STREAK_DONE = SW'(CONFIRM_WINS - 1);

    ctl_t          ctl_q, ctl_d;
    logic [SW-1:0] streak_q, streak_d;
    logic          mode_q;
    logic          mode_chg;
    logic          abort;
    logic          tmr_last;
    logic          win_done;
    logic          in_tol;
    logic          locked_q;
    logic [CW-1:0] total;

    assign mode_chg = (rate_hi != mode_q);
    assign abort    = !sig_det || !force_ref_n || mode_chg;
    assign win_done = (ctl_q.phase == PH_MEAS) && tmr_last && !abort;
    assign locked_q = ctl_q.locked;

    lfd_timer #(
        .TRAIN_LOG2 (TRAIN_LOG2),
        .WIN_LOG2   (WIN_LOG2)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clear     (abort),
        .sel_train (ctl_q.phase == PH_TRAIN),
        .last      (tmr_last)
    );

    lfd_pulse_acc #(
        .CW (CW)
    ) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (abort || (ctl_q.phase == PH_TRAIN)),
        .run   (ctl_q.phase == PH_MEAS),
        .close (tmr_last && (ctl_q.phase == PH_MEAS)),
        .pulse (rec_pulse),
        .total (total)
    );

    lfd_judge #(
        .CW            (CW),
        .WIN_LOG2      (WIN_LOG2),
        .PRESCALE_LOG2 (PRESCALE_LOG2),
        .PPM           (PPM)
    ) u_judge (
        .rate_hi (rate_hi),
        .total   (total),
        .in_tol  (in_tol)
    );

    always_comb begin
        ctl_d    = ctl_q;
        streak_d = streak_q;
        if (abort) begin
            ctl_d.phase  = PH_TRAIN;
            ctl_d.locked = 1'b0;
            streak_d     = '0;
        end else if ((ctl_q.phase == PH_TRAIN) && tmr_last) begin
            ctl_d.phase = PH_MEAS;
            streak_d    = '0;
        end else if (win_done) begin
            if (!in_tol) begin
                ctl_d.phase  = PH_TRAIN;
                ctl_d.locked = 1'b0;
                streak_d     = '0;
            end else if (!ctl_q.locked) begin
                if (streak_q == STREAK_DONE) begin
                    ctl_d.locked = 1'b1;
                end else begin
                    streak_d = streak_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '{phase: PH_TRAIN, locked: 1'b0};
            streak_q <= '0;
            mode_q   <= rate_hi;
        end else begin
            ctl_q    <= ctl_d;
            streak_q <= streak_d;
            mode_q   <= rate_hi;
        end
    end

    assign lock      = ctl_q.locked && sig_det && force_ref_n && !mode_chg && !rst;
    assign train_ref = (ctl_q.phase == PH_TRAIN) || !sig_det || !force_ref_n || rst;
endmodule

// File: rtl/lfd_checker.sv
module lfd_checker (
    input logic clk,
    input logic rst,
    input logic force_ref_n,
    input logic sig_det,
    input logic lock,
    input logic train_ref,
    input logic win_done,
    input logic in_tol,
    input logic locked_q
);
    // R3: force to reference blocks lock and drives training in the same cycle
    a_r3_force_blocks_lock: assert property (@(posedge clk) disable iff (rst)
        !force_ref_n |-> (!lock && train_ref));

    // R4: missing signal blocks lock
    a_r4_sigdet_blocks_lock: assert property (@(posedge clk) disable iff (rst)
        !sig_det |-> (!lock && train_ref));

    // R5: the lock state is only entered at the end of a good window
    a_r5_rise_at_window_end: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> $past(win_done && in_tol));

    // R6: a bad window clears lock and returns to training
    a_r6_drop_on_bad_window: assert property (@(posedge clk) disable iff (rst)
        (win_done && !in_tol) |=> (!locked_q && train_ref));

    // R10: lock and training never overlap
    a_r10_lock_excludes_train: assert property (@(posedge clk) disable iff (rst)
        lock |-> !train_ref);
endmodule

bind freq_lock_trainer lfd_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .force_ref_n (force_ref_n),
    .sig_det     (sig_det),
    .lock        (lock),
    .train_ref   (train_ref),
    .win_done    (win_done),
    .in_tol      (in_tol),
    .locked_q    (locked_q)
);

// File: tb/sim_freq_lock_trainer.sv
module sim_freq_lock_trainer;
    localparam int WIN_LOG2   = 10;
    localparam int TRAIN_LOG2 = 6;
    localparam int WIN_LEN    = 1 << WIN_LOG2;
    localparam int TRAIN_LEN  = 1 << TRAIN_LOG2;
    localparam int LOCK_TIME  = TRAIN_LEN + 2 * WIN_LEN;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rec_pulse = 1'b0;
    logic rate_hi = 1'b1;
    logic sig_det = 1'b1;
    logic force_ref_n = 1'b1;
    logic lock;
    logic train_ref;

    int n_chk = 0;
    int n_fail = 0;
    int step = 1024;
    logic [9:0] acc = '0;
    logic [11:0] acc_sum;

    always #5 clk = ~clk;

    freq_lock_trainer #(
        .WIN_LOG2      (WIN_LOG2),
        .TRAIN_LOG2    (TRAIN_LOG2),
        .PRESCALE_LOG2 (5),
        .PPM           (5000),
        .CONFIRM_WINS  (2)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .rec_pulse   (rec_pulse),
        .rate_hi     (rate_hi),
        .sig_det     (sig_det),
        .force_ref_n (force_ref_n),
        .lock        (lock),
        .train_ref   (train_ref)
    );

    // Exact-count pulse source: any WIN_LEN consecutive cycles carry exactly `step` pulses.
    always @(negedge clk) begin
        acc_sum = {2'b00, acc} + 12'(step);
        rec_pulse = (acc_sum >= 12'd1024);
        acc = (acc_sum >= 12'd1024) ? 10'(acc_sum - 12'd1024) : acc_sum[9:0];
    end

    function automatic int nom_count(logic hi);
        return hi ? 1024 : 256;
    endfunction

    function automatic int tol_count(logic hi);
        return hi ? 5 : 1;
    endfunction

    function automatic bit expect_lock(logic hi, int stp);
        int d;
        d = stp - nom_count(hi);
        if (d < 0) d = -d;
        return d <= tol_count(hi);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sig_det = 1'b1;
        force_ref_n = 1'b1;
        tick(3);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // counts edges after the current point until lock rises (0 if it never does)
    task automatic edges_to_lock(int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            #1;
            if (lock && n == 0) n = i;
        end
    endtask

    task automatic trial(logic hi, int stp, string req);
        bit ever;
        int rises;
        logic prev;
        bit exp;
        rate_hi = hi;
        step = stp;
        do_reset();
        ever = 0;
        rises = 0;
        prev = 1'b1;
        for (int i = 0; i < TRAIN_LEN + 3 * WIN_LEN; i++) begin
            @(posedge clk);
            #1;
            if (lock) ever = 1;
            if (train_ref && !prev) rises++;
            prev = train_ref;
        end
        exp = expect_lock(hi, stp);
        chk(lock == exp, req, int'(lock), int'(exp));
        if (!exp) begin
            chk(!ever, "R7 lock stays low when off", int'(ever), 0);
            chk(rises >= 2, "R7 training repeats", rises, 2);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n;
        int cnt;
        void'($urandom(32'd4711));

        // R8: reset state
        tick(2);
        chk(lock == 1'b0, "R8 lock in reset", int'(lock), 0);
        chk(train_ref == 1'b1, "R8 train in reset", int'(train_ref), 1);

        // R5: exact relock time at the nominal high rate
        rate_hi = 1'b1;
        step = 1024;
        do_reset();
        edges_to_lock(LOCK_TIME + 20, n);
        chk(n == LOCK_TIME, "R5 lock rise edge", n, LOCK_TIME);
        chk(train_ref == 1'b0, "R10 train released while locked", int'(train_ref), 0);

        // R5: one good window is not enough
        do_reset();
        tick(TRAIN_LEN + WIN_LEN + 5);
        chk(lock == 1'b0, "R5 single window no lock", int'(lock), 0);
        tick(WIN_LEN);

        // R3: force to reference
        @(negedge clk);
        force_ref_n = 1'b0;
        #1;
        chk(lock == 1'b0, "R3 force clears lock", int'(lock), 0);
        chk(train_ref == 1'b1, "R3 force drives train", int'(train_ref), 1);
        tick(4);
        @(negedge clk);
        force_ref_n = 1'b1;
        edges_to_lock(LOCK_TIME + 20, n);
        chk(n == LOCK_TIME, "R3 relock after force", n, LOCK_TIME);

        // R4: signal detect loss
        @(negedge clk);
        sig_det = 1'b0;
        #1;
        chk(lock == 1'b0, "R4 sigdet clears lock", int'(lock), 0);
        chk(train_ref == 1'b1, "R4 sigdet drives train", int'(train_ref), 1);
        tick(4);
        @(negedge clk);
        sig_det = 1'b1;
        edges_to_lock(LOCK_TIME + 20, n);
        chk(n == LOCK_TIME, "R4 relock after sigdet", n, LOCK_TIME);

        // R6: bad window while locked
        @(negedge clk);
        step = 1000;
        n = 0;
        for (int i = 0; i < 2 * WIN_LEN + 4; i++) begin
            @(posedge clk);
            #1;
            if (!lock) break;
        end
        chk(lock == 1'b0, "R6 lock drops on bad window", int'(lock), 0);
        cnt = 0;
        while (train_ref && cnt < 4 * TRAIN_LEN) begin
            cnt++;
            tick(1);
        end
        chk(cnt == TRAIN_LEN, "R6 training length", cnt, TRAIN_LEN);

        // R9: rate change while locked
        rate_hi = 1'b0;
        step = 256;
        do_reset();
        edges_to_lock(LOCK_TIME + 20, n);
        chk(n == LOCK_TIME, "R1 low rate lock", n, LOCK_TIME);
        @(negedge clk);
        rate_hi = 1'b1;
        #1;
        chk(lock == 1'b0, "R9 rate change clears lock", int'(lock), 0);
        tick(2);
        chk(train_ref == 1'b1, "R9 rate change restarts training", int'(train_ref), 1);
        edges_to_lock(TRAIN_LEN + 3 * WIN_LEN, n);
        chk(n == 0, "R9 no relock at wrong rate", n, 0);

        // R1: cross-rate streams
        trial(1'b0, 1024, "R1 high stream on low rate");
        trial(1'b1, 256, "R1 low stream on high rate");

        // R2: tolerance limits
        trial(1'b1, 1024 - 5, "R2 high lower limit");
        trial(1'b1, 1024 - 6, "R2 high beyond lower limit");
        trial(1'b0, 256 + 1, "R2 low upper limit");
        trial(1'b0, 256 + 2, "R2 low beyond upper limit");
        trial(1'b0, 256 - 1, "R2 low lower limit");
        trial(1'b0, 256 - 2, "R2 low beyond lower limit");

        // random offsets around nominal, R2 and R7
        for (int k = 0; k < 16; k++) begin
            logic hi;
            int off;
            hi = 1'($urandom_range(1, 0));
            if (hi) off = -int'($urandom_range(9, 0));
            else off = int'($urandom_range(6, 0)) - 3;
            trial(hi, nom_count(hi) + off, "R2 random offset");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule